// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is a parameterized serial chain of two-stage test cells that sits between a module's pads and its core logic. There is one cell for each input pad, between the pad and the core, and one cell for each output pad, between the core and the pad. Each cell has a first stage and a second stage. The first stage either takes a snapshot of the value crossing the cell or passes data serially along the chain. The second stage holds a value that can be driven in place of the functional value while test mode is on. Because the two stages are separate, moving data through the chain never disturbs what the core or the pads see.

The strobes that request a snapshot, a shift or a transfer into the second stage come from an external test-port state machine. The test-mode select also comes from outside. Instruction decoding is not part of this block. The chain runs on the test clock and is cleared by an active-low asynchronous test reset.

Each cell chooses its first-stage operation from three named operations: HOLD, CAPTURE and SHIFT. The choice depends only on the two strobes in the current cycle. With both strobes low the operation is HOLD. With capture high and shift low it is CAPTURE. With shift high the operation is SHIFT, whatever the capture strobe does. There is no stored state other than the two stages of each cell.

Top module: `bscan_chain`

## Requirements
- R1: The chain holds N_IN+N_OUT cells in this serial order: `scan_in`, then input cells 0 to N_IN-1, then output cells 0 to N_OUT-1, then `scan_out`. `scan_out` is driven directly by the first stage of the last output cell, with no extra register.
- R2: On a clock edge with `capture_en`=1 and `shift_en`=0, the first stage of input cell k loads `pin_in[k]`, and the first stage of output cell j loads `core_out[j]`.
- R3: On a clock edge with `shift_en`=1, each first stage loads the first stage of the cell before it, and input cell 0 loads `scan_in`. Shift takes priority when `capture_en` is also high.
- R4: On a clock edge with `capture_en`=0 and `shift_en`=0, every first stage keeps its value.
- R5: A second stage loads its own cell's first stage only on a clock edge with `update_en`=1, and otherwise keeps its value. Capture and shift therefore leave `core_in` and `pin_out` unchanged.
- R6: With `test_mode`=1, `core_in[k]` equals the second stage of input cell k, and `pin_out[j]` equals the second stage of output cell j.
- R7: With `test_mode`=0, `core_in` equals `pin_in` and `pin_out` equals `core_out`, combinationally and whatever the chain contents are.
- R8: `trst_n`=0 clears both stages of every cell to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| capture_en | input | 1 | Snapshot strobe for the first stages |
| shift_en | input | 1 | Serial shift strobe for the first stages |
| update_en | input | 1 | Transfer strobe for the second stages |
| test_mode | input | 1 | Selects the second-stage values as the cell outputs |
| scan_in | input | 1 | Serial data into input cell 0 |
| scan_out | output | 1 | Serial data from the last output cell |
| pin_in | input | N_IN | Values arriving at the input pads |
| core_in | output | N_IN | Values presented to the core inputs |
| core_out | input | N_OUT | Values produced by the core outputs |
| pin_out | output | N_OUT | Values driven to the output pads |

## Verification
The bench loads patterns whose ends can be told apart, so that a reversed chain order or a misplaced boundary between input and output cells shows up as bit-swapped data on unload. It shifts a full pattern in before any update strobe and confirms that the core and pad values stay frozen. A design that fed its outputs straight from the first stage would show the data rippling through during the shift. A cycle with both strobes high checks that the shift wins: a design that let capture win would reload the parallel values instead of moving the chain. The bench also pulses the reset between clock edges and expects cleared outputs at once, which a design with a synchronous reset would fail.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    // Operation applied to every first stage on a clock edge
    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2
    } cell_op_t;

    // Which side of the core a cell stands on
    typedef enum logic {
        SIDE_INPUT  = 1'b0,
        SIDE_OUTPUT = 1'b1
    } cell_side_t;

endpackage

// File: rtl/bscan_ctl.sv
module bscan_ctl
    import bscan_pkg::*;
(
    input  logic     capture_en,
    input  logic     shift_en,
    output cell_op_t op
);

    // Shift wins over capture (R3); both low holds (R4)
    always_comb begin
        unique case ({shift_en, capture_en})
            2'b00:        op = OP_HOLD;
            2'b01:        op = OP_CAPTURE;
            2'b10, 2'b11: op = OP_SHIFT;
            default:      op = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/bscan_cell.sv
module bscan_cell
    import bscan_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  cell_op_t op,
    input  logic     upd_en,
    input  logic     mode,
    input  logic     par_in,
    input  logic     ser_in,
    input  logic     func_in,
    output logic     ser_out,
    output logic     drive
);

    logic stage1_q;
    logic stage2_q;

    // First stage: capture or shift path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= 1'b0;
        end else begin
            unique case (op)
                OP_SHIFT:   stage1_q <= ser_in;
                OP_CAPTURE: stage1_q <= par_in;
                default:    stage1_q <= stage1_q;
            endcase
        end
    end

    // Second stage: changes only on the update strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage2_q <= 1'b0;
        end else if (upd_en) begin
            stage2_q <= stage1_q;
        end
    end

    always_comb begin
        ser_out = stage1_q;
        drive   = mode ? stage2_q : func_in;
    end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             capture_en,
    input  logic             shift_en,
    input  logic             update_en,
    input  logic             test_mode,
    input  logic             scan_in,
    output logic             scan_out,
    input  logic [N_IN-1:0]  pin_in,
    output logic [N_IN-1:0]  core_in,
    input  logic [N_OUT-1:0] core_out,
    output logic [N_OUT-1:0] pin_out
);

    localparam int LEN = N_IN + N_OUT;

    cell_op_t         op;
    logic [LEN-1:0]   link;      // first-stage value of each chain position
    logic [LEN-1:0]   ser_feed;  // serial input of each chain position
    logic [LEN-1:0]   par_val;   // parallel value seen by each position
    logic [LEN-1:0]   drv;       // value each position drives

    bscan_ctl u_ctl (
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .op         (op)
    );

    always_comb begin
        ser_feed = {link[LEN-2:0], scan_in};
        par_val  = {core_out, pin_in};
    end

    for (genvar k = 0; k < LEN; k++) begin : g_cell
        localparam cell_side_t SIDE = (k < N_IN) ? SIDE_INPUT : SIDE_OUTPUT;
        bscan_cell u_cell (
            .clk     (tck),
            .rst_n   (trst_n),
            .op      (op),
            .upd_en  (update_en),
            .mode    (test_mode),
            .par_in  (par_val[k]),
            .ser_in  (ser_feed[k]),
            .func_in (par_val[k]),
            .ser_out (link[k]),
            .drive   (drv[k])
        );
        if (SIDE == SIDE_INPUT) begin : g_in
            assign core_in[k] = drv[k];
        end else begin : g_out
            assign pin_out[k-N_IN] = drv[k];
        end
    end

    assign scan_out = link[LEN-1];

endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4
) (
    input logic             tck,
    input logic             trst_n,
    input logic             capture_en,
    input logic             shift_en,
    input logic             update_en,
    input logic             test_mode,
    input logic             scan_in,
    input logic             scan_out,
    input logic [N_IN-1:0]  pin_in,
    input logic [N_IN-1:0]  core_in,
    input logic [N_OUT-1:0] core_out,
    input logic [N_OUT-1:0] pin_out
);

    localparam int LEN = N_IN + N_OUT;
    localparam int CW  = $clog2(LEN + 1);

    logic [LEN-1:0] hist;
    logic [CW-1:0]  run;

    // Recent serial inputs and how many shifts since the last snapshot
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            hist <= '0;
            run  <= '0;
        end else if (shift_en) begin
            hist <= {hist[LEN-2:0], scan_in};
            if (run != CW'(LEN)) run <= run + 1'b1;
        end else if (capture_en) begin
            run <= '0;
        end
    end

    // R1, R3: a bit entering scan_in leaves scan_out after LEN shifts
    a_r3_shift_path: assert property (@(posedge tck) disable iff (!trst_n)
        (run == CW'(LEN)) |-> (scan_out == hist[LEN-1]));

    // R2: the last output cell takes the last core output on capture
    a_r2_capture_last: assert property (@(posedge tck) disable iff (!trst_n)
        (capture_en && !shift_en) |=> (scan_out == $past(core_out[N_OUT-1])));

    // R5: without an update strobe the driven test values stay put
    a_r5_hold_outputs: assert property (@(posedge tck) disable iff (!trst_n)
        (test_mode && $past(test_mode) && !$past(update_en))
        |-> ($stable(core_in) && $stable(pin_out)));

    // R7: functional mode passes both directions straight through
    a_r7_normal_pass: assert property (@(posedge tck) disable iff (!trst_n)
        !test_mode |-> (core_in == pin_in && pin_out == core_out));

    // R8: while reset is low the chain and test outputs read zero
    a_r8_reset_clear: assert property (@(posedge tck)
        !trst_n |-> (scan_out == 1'b0 &&
                     (!test_mode || (core_in == '0 && pin_out == '0))));

endmodule

bind bscan_chain bscan_chain_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
    .tck        (tck),
    .trst_n     (trst_n),
    .capture_en (capture_en),
    .shift_en   (shift_en),
    .update_en  (update_en),
    .test_mode  (test_mode),
    .scan_in    (scan_in),
    .scan_out   (scan_out),
    .pin_in     (pin_in),
    .core_in    (core_in),
    .core_out   (core_out),
    .pin_out    (pin_out)
);

// File: tb/sim_bscan_chain.sv
`timescale 1ns/1ps
module sim_bscan_chain;

    localparam int N_IN  = 4;
    localparam int N_OUT = 4;
    localparam int LEN   = N_IN + N_OUT;

    logic             tck = 1'b0;
    logic             trst_n;
    logic             capture_en, shift_en, update_en, test_mode, scan_in;
    logic             scan_out;
    logic [N_IN-1:0]  pin_in, core_in;
    logic [N_OUT-1:0] core_out, pin_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 tck = ~tck;

    bscan_chain #(.N_IN(N_IN), .N_OUT(N_OUT)) u0 (
        .tck(tck), .trst_n(trst_n), .capture_en(capture_en),
        .shift_en(shift_en), .update_en(update_en), .test_mode(test_mode),
        .scan_in(scan_in), .scan_out(scan_out), .pin_in(pin_in),
        .core_in(core_in), .core_out(core_out), .pin_out(pin_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock edge with the given strobes; returns 2 ns after the edge
    task automatic tick(input logic c, input logic s, input logic u, input logic si);
        capture_en = c; shift_en = s; update_en = u; scan_in = si;
        @(posedge tck);
        #2;
        capture_en = 0; shift_en = 0; update_en = 0; scan_in = 0;
    endtask

    // Position k of v ends in chain position k
    task automatic load(input logic [LEN-1:0] v);
        for (int i = 0; i < LEN; i++) tick(0, 1, 0, v[LEN-1-i]);
    endtask

    task automatic unload(output logic [LEN-1:0] v);
        for (int i = 0; i < LEN; i++) begin
            v[LEN-1-i] = scan_out;
            tick(0, 1, 0, 0);
        end
    endtask

    task automatic t_reset;
        test_mode = 1;
        #1;
        check("R8 reset core_in", 32'(core_in), 0);
        check("R8 reset pin_out", 32'(pin_out), 0);
        check("R8 reset scan_out", 32'(scan_out), 0);
    endtask

    task automatic t_normal;
        logic [LEN-1:0] got;
        test_mode = 0;
        load(8'hFF);
        tick(0, 0, 1, 0);
        for (int p = 0; p < 3; p++) begin
            pin_in   = 4'(4'h5 + 4'(p * 3));
            core_out = 4'(4'hC - 4'(p * 5));
            #1;
            check("R7 core_in follows pin_in", 32'(core_in), 32'(pin_in));
            check("R7 pin_out follows core_out", 32'(pin_out), 32'(core_out));
        end
        unload(got);
        check("R3 load/unload round trip", 32'(got), 32'hFF);
    endtask

    task automatic t_capture;
        logic [LEN-1:0] got;
        pin_in = 4'hA; core_out = 4'h3;
        tick(1, 0, 0, 0);
        check("R1 scan_out is last output cell", 32'(scan_out), 0);
        unload(got);
        check("R2 capture order", 32'(got), 32'h3A);
        pin_in = 4'h1; core_out = 4'h8;
        tick(1, 0, 0, 0);
        check("R1 scan_out after capture", 32'(scan_out), 1);
        unload(got);
        check("R2 capture second pattern", 32'(got), 32'h81);
    endtask

    task automatic t_update;
        logic [LEN-1:0] got;
        test_mode = 1;
        tick(0, 0, 1, 0);          // second stages := zeros left by unload
        load(8'hC5);
        check("R5 core_in frozen during shift", 32'(core_in), 0);
        check("R5 pin_out frozen during shift", 32'(pin_out), 0);
        tick(0, 0, 1, 0);
        check("R6 core_in from input cells", 32'(core_in), 32'h5);
        check("R6 pin_out from output cells", 32'(pin_out), 32'hC);
        // R4: idle cycles keep the chain
        for (int i = 0; i < 3; i++) tick(0, 0, 0, 0);
        unload(got);
        check("R4 hold keeps first stages", 32'(got), 32'hC5);
        check("R5 no strobe keeps core_in", 32'(core_in), 32'h5);
        check("R5 no strobe keeps pin_out", 32'(pin_out), 32'hC);
    endtask

    task automatic t_priority;
        logic [LEN-1:0] got;
        load(8'h96);
        pin_in = 4'h0; core_out = 4'h0;
        tick(1, 1, 0, 1);          // shift must win: 96 -> 2D
        unload(got);
        check("R3 shift beats capture", 32'(got), 32'h2D);
    endtask

    task automatic t_async_reset;
        test_mode = 1;
        load(8'hFF);
        tick(0, 0, 1, 0);
        check("R6 all ones before reset", 32'({pin_out, core_in}), 32'hFF);
        #1 trst_n = 0;
        #1;
        check("R8 async clear core_in", 32'(core_in), 0);
        check("R8 async clear pin_out", 32'(pin_out), 0);
        check("R8 async clear scan_out", 32'(scan_out), 0);
        @(negedge tck);
        trst_n = 1;
        #1;
    endtask

    initial begin
        trst_n = 0; capture_en = 0; shift_en = 0; update_en = 0;
        test_mode = 0; scan_in = 0; pin_in = '0; core_out = '0;
        #23;
        t_reset();
        trst_n = 1;
        #10;
        t_normal();
        t_capture();
        t_update();
        t_priority();
        t_async_reset();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge tck);
                total++; bad++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule